// File: doc/BRIEF.md
# Fully Associative Branch Target Buffer

This block predicts where instruction fetch should go next. It is a small content-addressed store. Each slot holds a complete fetch address and the address that followed it the last time a taken control transfer resolved there. Every cycle the fetch unit presents its current PC. If a valid slot carries exactly that PC, the stored target is returned in the same cycle, so fetch can redirect without waiting for decode. The block makes no distinction between conditional branches, direct jumps and register-indirect jumps; any of them may be allocated.

Training comes from the resolve stage through one update port. A taken outcome refreshes the matching slot or claims a new one. A not-taken outcome evicts the matching slot. A new slot is taken from the free slots first, lowest index first. When no slot is free, a rotating pointer picks the slot to overwrite. A synchronous flush empties the whole table in one cycle.

Top module: `btb_fa`

## Requirements
- R1: The lookup is combinational. When a valid slot's tag equals `fetch_pc_i`, `pred_hit_o` is 1 and `pred_target_o` is that slot's target in the same cycle. Otherwise `pred_hit_o` is 0 and `pred_target_o` is 0.
- R2: After synchronous reset every slot is invalid, so every lookup misses.
- R3: A taken update (`upd_valid_i`=1, `upd_taken_i`=1) for a PC held in no valid slot stores the PC and target. The entry is visible to lookups from the cycle after the update edge. A lookup in the update cycle still sees the old contents.
- R4: A taken update for a PC that already hits overwrites that slot's target in place and creates no second copy. A single not-taken update for that PC afterwards leaves it missing.
- R5: A not-taken update (`upd_taken_i`=0) for a PC that hits invalidates that slot. A not-taken update for a PC that misses changes nothing.
- R6: When at least one slot is invalid, an allocation goes to the lowest-index invalid slot, and the rotating pointer does not move.
- R7: When all slots are valid, an allocation overwrites the slot named by the rotating pointer. The pointer starts at slot 0, advances by one per such overwrite, and wraps from the last slot to 0.
- R8: `flush_i`=1 invalidates every slot at the next edge and returns the rotating pointer to 0. An update in the same cycle is discarded.
- R9: The tag is the full 32-bit PC. Two PCs that differ in any bit, including bit 31, never alias.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flush_i | input | 1 | Invalidate all slots, reset the rotating pointer |
| fetch_pc_i | input | 32 | PC being fetched this cycle |
| pred_hit_o | output | 1 | A valid slot matches `fetch_pc_i` |
| pred_target_o | output | 32 | Predicted next PC, 0 on a miss |
| upd_valid_i | input | 1 | A resolved control transfer is presented |
| upd_taken_i | input | 1 | 1 = taken (write), 0 = not taken (evict) |
| upd_pc_i | input | 32 | PC of the resolved transfer |
| upd_target_i | input | 32 | Resolved next PC for a taken transfer |

## Verification
The lookup is driven with PCs that were never trained, with trained PCs, and with a PC that differs from a trained one only in its top bit. Together these separate a true full-tag match from partial matching or a stuck hit. The table is filled to capacity and then pushed with more new PCs than it has slots. Which earlier PCs disappear shows the rotating order and its wrap. Holes are then punched with not-taken updates, which shows that free slots are used before the pointer and that the pointer is left in place. A flush is issued together with a pending update and with a pointer that has already moved, and the bench refills the table afterwards; this reveals any leftover state.

// File: rtl/btb_pkg.sv
package btb_pkg;

    localparam int unsigned BTB_PC_W    = 32;
    localparam int unsigned BTB_ENTRIES = 32;

    typedef logic [BTB_PC_W-1:0] pc_t;

    // What the update port does to the table this cycle
    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_REFRESH = 2'd1,
        ACT_ALLOC   = 2'd2,
        ACT_KILL    = 2'd3
    } btb_act_e;

    typedef struct packed {
        logic valid;
        logic taken;
        pc_t  pc;
        pc_t  target;
    } btb_train_t;

    typedef struct packed {
        logic hit;
        pc_t  target;
    } btb_pred_t;

    function automatic btb_act_e btb_decide(input btb_train_t t,
                                            input logic flush,
                                            input logic present);
        if (!t.valid || flush) return ACT_NONE;
        if (t.taken)           return present ? ACT_REFRESH : ACT_ALLOC;
        return present ? ACT_KILL : ACT_NONE;
    endfunction

endpackage

// File: rtl/btb_first_one.sv
module btb_first_one #(
    parameter int unsigned N     = 32,
    parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);
    // Lowest set bit wins
    always_comb begin
        idx_o = '0;
        any_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IDX_W'(i);
                any_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/btb_cam_match.sv
module btb_cam_match
    import btb_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input  pc_t          key_i,
    input  pc_t          tag_i [N],
    input  logic [N-1:0] vld_i,
    output logic [N-1:0] hit_o
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_o[g] = vld_i[g] && (tag_i[g] == key_i);
    end
endmodule

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int unsigned N     = 32,
    parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_i,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  pc_t              wr_tag_i,
    input  pc_t              wr_tgt_i,
    input  logic             kill_en_i,
    input  logic [IDX_W-1:0] kill_idx_i,
    output logic [N-1:0]     vld_o,
    output pc_t              tag_o [N],
    output pc_t              tgt_o [N]
);
    logic [N-1:0] vld_q;
    pc_t          tag_q [N];
    pc_t          tgt_q [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int i = 0; i < N; i++) begin
                tag_q[i] <= '0;
                tgt_q[i] <= '0;
            end
        end else if (flush_i) begin
            vld_q <= '0;
        end else begin
            if (wr_en_i) begin
                vld_q[wr_idx_i] <= 1'b1;
                tag_q[wr_idx_i] <= wr_tag_i;
                tgt_q[wr_idx_i] <= wr_tgt_i;
            end
            if (kill_en_i) begin
                vld_q[kill_idx_i] <= 1'b0;
            end
        end
    end

    assign vld_o = vld_q;
    assign tag_o = tag_q;
    assign tgt_o = tgt_q;

    // R8: a flush leaves nothing valid
    p_flush_clear_r8: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (vld_q == '0));

    // R3: a write lands with its tag and becomes valid
    p_write_lands_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && !flush_i) |=>
            (vld_q[$past(wr_idx_i)] && tag_q[$past(wr_idx_i)] == $past(wr_tag_i)
             && tgt_q[$past(wr_idx_i)] == $past(wr_tgt_i)));
endmodule

// File: rtl/btb_victim.sv
module btb_victim #(
    parameter int unsigned N     = 32,
    parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_i,
    input  logic             alloc_i,
    input  logic [N-1:0]     vld_i,
    output logic [IDX_W-1:0] victim_o
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] free_idx;
    logic             has_free;

    btb_first_one #(.N(N), .IDX_W(IDX_W)) u_free (
        .req_i (~vld_i),
        .idx_o (free_idx),
        .any_o (has_free)
    );

    assign victim_o = has_free ? free_idx : ptr_q;

    always_ff @(posedge clk) begin
        if (rst || flush_i) begin
            ptr_q <= '0;
        end else if (alloc_i && !has_free) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    // R6: with room in the table, the chosen slot is a free one
    p_free_first_r6: assert property (@(posedge clk) disable iff (rst)
        (alloc_i && (vld_i != '1)) |-> !vld_i[victim_o]);

    // R6: allocating into a free slot leaves the pointer alone
    p_ptr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (alloc_i && (vld_i != '1) && !flush_i) |=> $stable(ptr_q));
endmodule

// File: rtl/btb_fa.sv
module btb_fa
    import btb_pkg::*;
#(
    parameter int unsigned ENTRIES = BTB_ENTRIES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                flush_i,
    input  logic [BTB_PC_W-1:0] fetch_pc_i,
    output logic                pred_hit_o,
    output logic [BTB_PC_W-1:0] pred_target_o,
    input  logic                upd_valid_i,
    input  logic                upd_taken_i,
    input  logic [BTB_PC_W-1:0] upd_pc_i,
    input  logic [BTB_PC_W-1:0] upd_target_i
);
    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] vld;
    pc_t                tags [ENTRIES];
    pc_t                tgts [ENTRIES];

    logic [ENTRIES-1:0] lk_match, up_match;
    logic [IDX_W-1:0]   lk_idx, up_idx, victim_idx, wr_idx;
    logic               lk_any, up_any;

    btb_train_t train;
    btb_pred_t  pred;
    btb_act_e   act;

    assign train = '{valid: upd_valid_i, taken: upd_taken_i,
                     pc: upd_pc_i, target: upd_target_i};

    // Fetch-side lookup
    btb_cam_match #(.N(ENTRIES)) u_lk_cam (
        .key_i (fetch_pc_i), .tag_i (tags), .vld_i (vld), .hit_o (lk_match)
    );
    btb_first_one #(.N(ENTRIES), .IDX_W(IDX_W)) u_lk_sel (
        .req_i (lk_match), .idx_o (lk_idx), .any_o (lk_any)
    );

    // Resolve-side lookup
    btb_cam_match #(.N(ENTRIES)) u_up_cam (
        .key_i (train.pc), .tag_i (tags), .vld_i (vld), .hit_o (up_match)
    );
    btb_first_one #(.N(ENTRIES), .IDX_W(IDX_W)) u_up_sel (
        .req_i (up_match), .idx_o (up_idx), .any_o (up_any)
    );

    assign act    = btb_decide(train, flush_i, up_any);
    assign wr_idx = (act == ACT_REFRESH) ? up_idx : victim_idx;

    btb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk      (clk),
        .rst      (rst),
        .flush_i  (flush_i),
        .alloc_i  (act == ACT_ALLOC),
        .vld_i    (vld),
        .victim_o (victim_idx)
    );

    btb_store #(.N(ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .flush_i    (flush_i),
        .wr_en_i    ((act == ACT_REFRESH) || (act == ACT_ALLOC)),
        .wr_idx_i   (wr_idx),
        .wr_tag_i   (train.pc),
        .wr_tgt_i   (train.target),
        .kill_en_i  (act == ACT_KILL),
        .kill_idx_i (up_idx),
        .vld_o      (vld),
        .tag_o      (tags),
        .tgt_o      (tgts)
    );

    always_comb begin
        pred.hit    = lk_any;
        pred.target = lk_any ? tgts[lk_idx] : '0;
    end

    assign pred_hit_o    = pred.hit;
    assign pred_target_o = pred.target;

    // R1: a reported hit points at a valid slot holding the fetch PC
    p_hit_tag_r1: assert property (@(posedge clk) disable iff (rst)
        pred_hit_o |-> (vld[lk_idx] && tags[lk_idx] == fetch_pc_i));

    // R4: training never leaves two slots holding the same PC
    p_no_dup_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match) && $onehot0(up_match));

    // R5: an eviction clears the slot it matched
    p_kill_effect_r5: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_KILL) |=> !vld[$past(up_idx)]);

    // R2: nothing hits in the first cycle after reset
    p_reset_empty_r2: assert property (@(posedge clk)
        $fell(rst) |-> !pred_hit_o);
endmodule

// File: tb/btb_fa_tb_top.sv
module btb_fa_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSLOT      = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush_i = 1'b0;
    logic [31:0] fetch_pc_i = '0;
    logic        pred_hit_o;
    logic [31:0] pred_target_o;
    logic        upd_valid_i = 1'b0;
    logic        upd_taken_i = 1'b0;
    logic [31:0] upd_pc_i = '0;
    logic [31:0] upd_target_i = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    btb_fa dut_i (
        .clk           (clk),
        .rst           (rst),
        .flush_i       (flush_i),
        .fetch_pc_i    (fetch_pc_i),
        .pred_hit_o    (pred_hit_o),
        .pred_target_o (pred_target_o),
        .upd_valid_i   (upd_valid_i),
        .upd_taken_i   (upd_taken_i),
        .upd_pc_i      (upd_pc_i),
        .upd_target_i  (upd_target_i)
    );

    function automatic logic [31:0] a_pc(input int i);
        return 32'h0000_1000 + 32'(i) * 4;
    endfunction
    function automatic logic [31:0] a_tg(input int i);
        return 32'h4000_0000 + 32'(i) * 16;
    endfunction
    function automatic logic [31:0] x_pc(input int k);
        return 32'h0000_2000 + 32'(k) * 4;
    endfunction
    function automatic logic [31:0] x_tg(input int k);
        return 32'h5000_0000 + 32'(k) * 16;
    endfunction

    // Combinational lookup check, called between edges
    task automatic look(input logic [31:0] pc, input logic exp_hit,
                        input logic [31:0] exp_tgt, input string req);
        logic [31:0] want;
        fetch_pc_i = pc;
        #1;
        want = exp_hit ? exp_tgt : 32'h0;
        n_checks++;
        if (pred_hit_o !== exp_hit || pred_target_o !== want) begin
            n_fail++;
            $display("FAIL %s pc=%h: hit=%0b target=%h, expected hit=%0b target=%h",
                     req, pc, pred_hit_o, pred_target_o, exp_hit, want);
        end
    endtask

    task automatic upd(input logic [31:0] pc, input logic [31:0] tgt,
                       input logic taken);
        @(negedge clk);
        upd_valid_i  = 1'b1;
        upd_taken_i  = taken;
        upd_pc_i     = pc;
        upd_target_i = tgt;
        @(negedge clk);
        upd_valid_i  = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush_i = 1'b1;
        @(negedge clk);
        flush_i = 1'b0;
    endtask

    task automatic t_reset();
        look(32'h0000_1000, 1'b0, 32'h0, "R2");
        look(32'h0000_0000, 1'b0, 32'h0, "R2");
        look(32'hFFFF_FFFC, 1'b0, 32'h0, "R1");
    endtask

    task automatic t_basic();
        // R3: same-cycle lookup still sees the old contents
        @(negedge clk);
        upd_valid_i = 1'b1; upd_taken_i = 1'b1;
        upd_pc_i = 32'h0000_0100; upd_target_i = 32'h0000_0800;
        look(32'h0000_0100, 1'b0, 32'h0, "R3");
        @(negedge clk);
        upd_valid_i = 1'b0;
        look(32'h0000_0100, 1'b1, 32'h0000_0800, "R3");
        look(32'h0000_0104, 1'b0, 32'h0, "R1");
        // R9: a PC differing only in bit 31 does not alias
        look(32'h8000_0100, 1'b0, 32'h0, "R9");
        upd(32'h8000_0100, 32'h0000_0C00, 1'b1);
        look(32'h8000_0100, 1'b1, 32'h0000_0C00, "R9");
        look(32'h0000_0100, 1'b1, 32'h0000_0800, "R9");
    endtask

    task automatic t_refresh();
        upd(32'h0000_0100, 32'h0000_0900, 1'b1);
        look(32'h0000_0100, 1'b1, 32'h0000_0900, "R4");
        upd(32'h0000_0100, 32'h0, 1'b0);
        look(32'h0000_0100, 1'b0, 32'h0, "R4");
        // R5: evicting an absent PC changes nothing
        upd(32'h0000_0300, 32'h0, 1'b0);
        look(32'h8000_0100, 1'b1, 32'h0000_0C00, "R5");
        look(32'h0000_0300, 1'b0, 32'h0, "R5");
    endtask

    task automatic t_fill_rotate();
        // R8: flush with a concurrent update
        @(negedge clk);
        flush_i = 1'b1;
        upd_valid_i = 1'b1; upd_taken_i = 1'b1;
        upd_pc_i = 32'h0000_0700; upd_target_i = 32'h0000_0704;
        @(negedge clk);
        flush_i = 1'b0; upd_valid_i = 1'b0;
        look(32'h0000_0700, 1'b0, 32'h0, "R8");
        look(32'h8000_0100, 1'b0, 32'h0, "R8");
        for (int i = 0; i < NSLOT; i++) upd(a_pc(i), a_tg(i), 1'b1);
        look(a_pc(0), 1'b1, a_tg(0), "R3");
        look(a_pc(NSLOT - 1), 1'b1, a_tg(NSLOT - 1), "R3");
        // R7: table full, pointer at slot 0
        upd(x_pc(1), x_tg(1), 1'b1);
        look(a_pc(0), 1'b0, 32'h0, "R7");
        look(x_pc(1), 1'b1, x_tg(1), "R7");
        look(a_pc(1), 1'b1, a_tg(1), "R7");
        upd(x_pc(2), x_tg(2), 1'b1);
        look(a_pc(1), 1'b0, 32'h0, "R7");
        look(a_pc(2), 1'b1, a_tg(2), "R7");
        for (int k = 3; k <= NSLOT; k++) upd(x_pc(k), x_tg(k), 1'b1);
        look(a_pc(NSLOT - 1), 1'b0, 32'h0, "R7");
        // R7: wrap back to slot 0, which holds x1
        upd(x_pc(NSLOT + 1), x_tg(NSLOT + 1), 1'b1);
        look(x_pc(1), 1'b0, 32'h0, "R7");
        look(x_pc(2), 1'b1, x_tg(2), "R7");
    endtask

    task automatic t_free_first();
        // slot 1 holds x2, slot 9 holds x10, pointer at slot 1
        upd(x_pc(2), 32'h0, 1'b0);
        upd(x_pc(10), 32'h0, 1'b0);
        look(x_pc(2), 1'b0, 32'h0, "R5");
        upd(32'h0000_3000, 32'h0000_3100, 1'b1);
        look(x_pc(3), 1'b1, x_tg(3), "R6");
        upd(32'h0000_3004, 32'h0000_3104, 1'b1);
        look(x_pc(11), 1'b1, x_tg(11), "R6");
        // full again; pointer did not move, so slot 1 is next
        upd(32'h0000_3008, 32'h0000_3108, 1'b1);
        look(32'h0000_3000, 1'b0, 32'h0, "R6");
        look(32'h0000_3004, 1'b1, 32'h0000_3104, "R6");
        look(32'h0000_3008, 1'b1, 32'h0000_3108, "R6");
        look(x_pc(4), 1'b1, x_tg(4), "R6");
    endtask

    task automatic t_flush_ptr();
        // pointer sits at slot 2 before this flush
        do_flush();
        look(x_pc(4), 1'b0, 32'h0, "R8");
        for (int i = 0; i < NSLOT; i++) upd(a_pc(i), a_tg(i), 1'b1);
        upd(x_pc(40), x_tg(40), 1'b1);
        look(a_pc(0), 1'b0, 32'h0, "R8");
        look(a_pc(2), 1'b1, a_tg(2), "R8");
        look(x_pc(40), 1'b1, x_tg(40), "R8");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_refresh();
        t_fill_rotate();
        t_free_first();
        t_flush_ptr();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule